// File: doc/BRIEF.md
# Two-Word Instruction Fetch Unit

This block is the fetch stage of a small multi-step processor with 16-bit instruction words. It holds the program counter and a private, read-only instruction store. When the control unit pulses the fetch strobe, the unit reads the word at the program counter and also the word that follows it. That second word may carry an address or a constant. The unit reads it every time, whether or not the instruction uses it. Both words leave the unit together with the program counter they came from, so a later stage can work out where execution goes next.

The unit never advances its own program counter. A downstream stage computes the next address and returns it once the current instruction has finished. The control unit then latches that address with a load strobe. The counter's input comes from a two-way selector. One leg carries the returned address and the other carries a constant zero. The control unit's zero select drives the counter back to address zero, which restarts execution from the beginning.

Top module: `ifetch_unit`

## Requirements
- R1: While `rst_n` is low, the program counter is 0 and `valid_o`, `pc_o`, `instr_o` and `operand_o` are all 0. The first fetch after reset, made with no load and no zero select, returns address 0.
- R2: When `sel_zero` is high at a rising clock edge, the program counter becomes 0 at that edge, whatever `load_pc` and `next_pc` are.
- R3: When `load_pc` is high and `sel_zero` is low at a rising edge, the program counter takes the value of `next_pc` at that edge.
- R4: When neither `load_pc` nor `sel_zero` is high, the program counter keeps its value. Back-to-back fetches with no load return the same address.
- R5: When `fetch` is high at an edge, the following cycle shows `pc_o` = A and `instr_o` = word[A], where A is the program counter value after that edge's load or zero select.
- R6: In the same cycle, `operand_o` = word[(A+1) mod 4096]. This word is read on every fetch, and the address after 4095 wraps to 0.
- R7: `valid_o` is high in exactly the one cycle that follows an edge with `fetch` high, and low after every edge with `fetch` low.
- R8: After an edge with `fetch` low, `pc_o`, `instr_o` and `operand_o` keep their previous values.
- R9: With the default parameters, word[a] = (a × 0x0105 + 0xA5C3) mod 65536 for every address a from 0 to 4095.
- R10: If `load_pc` and `fetch` arrive in the same cycle, the load is applied first and the fetch uses the newly loaded address. If `sel_zero` and `fetch` arrive together, the fetch uses address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_zero | input | 1 | Control select that steers the counter to address zero |
| load_pc | input | 1 | Strobe that latches the returned next address |
| next_pc | input | 12 | Next address supplied by a downstream stage |
| fetch | input | 1 | Fetch trigger from the control unit |
| instr_o | output | 16 | Instruction word at the program counter |
| operand_o | output | 16 | Word following the instruction (speculative second word) |
| pc_o | output | 12 | Program counter the two words were read from |
| valid_o | output | 1 | One-cycle qualifier for the three outputs above |

## Verification
Repeated fetches with no load are used first. A unit that counts on its own would return a new address each time, so these fetches expose it. Loads that land in the same cycle as a fetch, and loads that land in a different cycle, show whether the fetch uses the new counter value or the old one. Addresses 4094 and 4095 test whether the second-word address wraps to 0. Zero select is driven together with a load, and also together with a fetch, to confirm that zero select wins over both. A long pseudo-random mix of strobes with idle gaps between them exercises the single-cycle valid pulse and the holding of the outputs between fetches. A reset in the middle of the run shows that every output and the counter return to zero.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

   // Program counter source chosen by the input selector
   typedef enum logic [1:0] {
      PC_HOLD = 2'd0,
      PC_LOAD = 2'd1,
      PC_ZERO = 2'd2
   } pc_src_e;

   // Content rule for the built-in instruction store
   function automatic logic [31:0] rom_word(input int unsigned addr,
                                            input logic [31:0] mul,
                                            input logic [31:0] seed);
      return addr * mul + seed;
   endfunction

endpackage

// File: rtl/ifetch_pc_sel.sv
module ifetch_pc_sel #(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_zero,
   input  logic              load_pc,
   input  logic [ADDR_W-1:0] next_pc,
   output logic [ADDR_W-1:0] pc_q,
   output logic [ADDR_W-1:0] pc_d
);
   import ifetch_pkg::*;

   localparam logic [ADDR_W-1:0] ZERO_ADDR = '0;

   pc_src_e src;

   // Zero select outranks the load strobe
   always_comb begin
      if (sel_zero)     src = PC_ZERO;
      else if (load_pc) src = PC_LOAD;
      else              src = PC_HOLD;
   end

   always_comb begin
      case (src)
         PC_ZERO: pc_d = ZERO_ADDR;
         PC_LOAD: pc_d = next_pc;
         default: pc_d = pc_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= ZERO_ADDR;
      else        pc_q <= pc_d;
   end

endmodule

// File: rtl/ifetch_imem.sv
module ifetch_imem #(
   parameter int          ADDR_W   = 12,
   parameter int          DATA_W   = 16,
   parameter int          NPORT    = 2,
   parameter logic [31:0] ROM_MUL  = 32'h0000_0105,
   parameter logic [31:0] ROM_SEED = 32'h0000_A5C3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rd_en,
   input  logic [ADDR_W-1:0]            base_addr,
   output logic [NPORT-1:0][DATA_W-1:0] rd_data
);
   import ifetch_pkg::*;

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         logic [31:0] w;
         w = rom_word(i, ROM_MUL, ROM_SEED);
         mem[i] = w[DATA_W-1:0];
      end
   end

   // One read port per consecutive word; the address wraps with the counter width
   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic [ADDR_W-1:0] addr_p;
      assign addr_p = base_addr + ADDR_W'(p);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rd_data[p] <= '0;
         else if (rd_en) rd_data[p] <= mem[addr_p];
      end
   end

endmodule

// File: rtl/ifetch_out_reg.sv
module ifetch_out_reg #(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch,
   input  logic [ADDR_W-1:0] pc_d,
   output logic [ADDR_W-1:0] pc_o,
   output logic              valid_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_o    <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= fetch;
         if (fetch) pc_o <= pc_d;
      end
   end

endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit #(
   parameter int          ADDR_W   = 12,
   parameter int          DATA_W   = 16,
   parameter logic [31:0] ROM_MUL  = 32'h0000_0105,
   parameter logic [31:0] ROM_SEED = 32'h0000_A5C3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_zero,
   input  logic              load_pc,
   input  logic [ADDR_W-1:0] next_pc,
   input  logic              fetch,
   output logic [DATA_W-1:0] instr_o,
   output logic [DATA_W-1:0] operand_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic              valid_o
);

   localparam int NWORDS = 2;

   initial begin
      assert (ADDR_W >= 2 && ADDR_W <= 14)
         else $error("ifetch_unit: ADDR_W out of range");
      assert (DATA_W >= 8 && DATA_W <= 32)
         else $error("ifetch_unit: DATA_W out of range");
   end

   logic [ADDR_W-1:0]            pc_q;
   logic [ADDR_W-1:0]            pc_d;
   logic [NWORDS-1:0][DATA_W-1:0] words;

   ifetch_pc_sel #(.ADDR_W(ADDR_W)) u_pc (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_zero (sel_zero),
      .load_pc  (load_pc),
      .next_pc  (next_pc),
      .pc_q     (pc_q),
      .pc_d     (pc_d)
   );

   // Fetch addresses from the selector output, so a same-cycle load wins
   ifetch_imem #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .NPORT    (NWORDS),
      .ROM_MUL  (ROM_MUL),
      .ROM_SEED (ROM_SEED)
   ) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (fetch),
      .base_addr (pc_d),
      .rd_data   (words)
   );

   ifetch_out_reg #(.ADDR_W(ADDR_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .fetch   (fetch),
      .pc_d    (pc_d),
      .pc_o    (pc_o),
      .valid_o (valid_o)
   );

   assign instr_o   = words[0];
   assign operand_o = words[1];

endmodule

// File: rtl/ifetch_unit_chk.sv
module ifetch_unit_chk #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_zero,
   input logic              load_pc,
   input logic [ADDR_W-1:0] next_pc,
   input logic              fetch,
   input logic [DATA_W-1:0] instr_o,
   input logic [DATA_W-1:0] operand_o,
   input logic [ADDR_W-1:0] pc_o,
   input logic              valid_o,
   input logic [ADDR_W-1:0] pc_q
);

   AST_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      sel_zero |=> (pc_q == '0)); // R2

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (load_pc && !sel_zero) |=> (pc_q == $past(next_pc))); // R3

   AST_PC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_pc && !sel_zero) |=> $stable(pc_q)); // R4

   AST_FETCH_NEW_PC: assert property (@(posedge clk) disable iff (!rst_n)
      fetch |=> (pc_o == pc_q)); // R10

   AST_VALID_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      fetch |=> valid_o); // R7

   AST_VALID_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch |=> !valid_o); // R7

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch |=> ($stable(pc_o) && $stable(instr_o) && $stable(operand_o))); // R8

endmodule

bind ifetch_unit ifetch_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_ifetch_unit.sv
module sim_ifetch_unit;

   localparam int AW = 12;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel_zero = 1'b0;
   logic          load_pc = 1'b0;
   logic [AW-1:0] next_pc = '0;
   logic          fetch = 1'b0;
   logic [DW-1:0] instr_o;
   logic [DW-1:0] operand_o;
   logic [AW-1:0] pc_o;
   logic          valid_o;

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct {
      logic          vld;
      logic [AW-1:0] pc;
      logic [DW-1:0] ins;
      logic [DW-1:0] opd;
      string         tag;
   } exp_t;

   exp_t          sb[$];
   logic [AW-1:0] m_pc;
   exp_t          m_last;

   always #5 clk = ~clk;

   ifetch_unit u0 (
      .clk(clk), .rst_n(rst_n), .sel_zero(sel_zero), .load_pc(load_pc),
      .next_pc(next_pc), .fetch(fetch), .instr_o(instr_o),
      .operand_o(operand_o), .pc_o(pc_o), .valid_o(valid_o)
   );

   // Store content rule of R9
   function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
      logic [31:0] t;
      t = 32'(a) * 32'h0105 + 32'hA5C3;
      return t[DW-1:0];
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_pc       = '0;
      m_last.vld = 1'b0;
      m_last.pc  = '0;
      m_last.ins = '0;
      m_last.opd = '0;
      m_last.tag = "R1";
   endtask

   // Driver: apply one cycle of strobes and push what the next cycle must show
   task automatic cyc(input logic f, input logic l, input logic s,
                      input logic [AW-1:0] n, input string tag);
      exp_t e;
      @(negedge clk);
      fetch = f; load_pc = l; sel_zero = s; next_pc = n;
      if (s)      m_pc = '0;
      else if (l) m_pc = n;
      if (f) begin
         e.vld = 1'b1;
         e.pc  = m_pc;
         e.ins = word_at(m_pc);
         e.opd = word_at(m_pc + 1'b1);
         e.tag = tag;
         m_last = e;
      end else begin
         e = m_last;
         e.vld = 1'b0;
         e.tag = tag;
      end
      sb.push_back(e);
   endtask

   task automatic idle_drive();
      @(negedge clk);
      fetch = 1'b0; load_pc = 1'b0; sel_zero = 1'b0;
   endtask

   // Monitor: compare one item per cycle, just after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.vld ? "R7" : "R7", "valid_o", 32'(valid_o), 32'(e.vld));
            if (e.vld) begin
               check(e.tag, "pc_o R5", 32'(pc_o), 32'(e.pc));
               check(e.tag, "instr_o R5", 32'(instr_o), 32'(e.ins));
               check(e.tag, "operand_o R6", 32'(operand_o), 32'(e.opd));
            end else begin
               check("R8", "pc_o hold", 32'(pc_o), 32'(e.pc));
               check("R8", "instr_o hold", 32'(instr_o), 32'(e.ins));
               check("R8", "operand_o hold", 32'(operand_o), 32'(e.opd));
            end
         end
      end
   end

   task automatic check_reset_state();
      check("R1", "valid_o in reset", 32'(valid_o), 32'd0);
      check("R1", "pc_o in reset", 32'(pc_o), 32'd0);
      check("R1", "instr_o in reset", 32'(instr_o), 32'd0);
      check("R1", "operand_o in reset", 32'(operand_o), 32'd0);
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      check_reset_state();
      rst_n = 1'b1;

      // R1: first fetch after reset reads address 0
      cyc(1, 0, 0, 12'h000, "R1");
      // R4: repeat fetch, no self-increment
      cyc(1, 0, 0, 12'h000, "R4");
      // R3: load alone, then fetch
      cyc(0, 1, 0, 12'h00A, "R3");
      cyc(1, 0, 0, 12'h3FF, "R3");
      cyc(1, 0, 0, 12'h3FF, "R4");
      // R8: idle cycles keep outputs
      cyc(0, 0, 0, 12'h123, "R8");
      cyc(0, 0, 0, 12'h456, "R8");
      // R10 and R6: same-cycle load and fetch at the top addresses
      cyc(1, 1, 0, 12'hFFF, "R10");
      cyc(1, 1, 0, 12'hFFE, "R6");
      cyc(1, 0, 0, 12'h000, "R6");
      // R2: zero select beats a load, with and without a fetch
      cyc(1, 1, 1, 12'h777, "R2");
      cyc(0, 1, 0, 12'h800, "R3");
      cyc(0, 1, 1, 12'h801, "R2");
      cyc(1, 0, 0, 12'h000, "R2");
      cyc(1, 0, 1, 12'h000, "R10");
      // R9: a spread of addresses checks the content rule
      for (int k = 0; k < 32; k++)
         cyc(1, 1, 0, AW'(k * 131 + 7), "R9");
      // R7/R8: pseudo-random strobe mix
      for (int k = 0; k < 400; k++) begin
         logic [31:0] r;
         r = $urandom;
         cyc(r[0], r[1], (r[4:2] == 3'b000), r[27:16], "R5");
      end
      idle_drive();
      repeat (3) @(posedge clk);
      #2;

      // Mid-run reset
      @(negedge clk);
      rst_n = 1'b0;
      sb.delete();
      model_reset();
      @(negedge clk);
      check_reset_state();
      rst_n = 1'b1;
      cyc(1, 0, 0, 12'h000, "R1");
      cyc(0, 0, 0, 12'h000, "R8");
      idle_drive();
      repeat (3) @(posedge clk);
      #2;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule